// File: doc/BRIEF.md
# Indirect Shared RAM Access Port

This block is a byte-wide register window through which a host processor reaches the local RAM of a coprocessor without mapping that RAM into its own address space. The host loads a RAM address one byte at a time into two address registers. It then moves data through a single data register, and each data access turns into one RAM read or write at the current address. When auto-increment is enabled, the address steps forward after every data access. This lets the host upload, download or compare a block of code or a message buffer after one address load.

A fourth register combines control and status. It holds:
- run and bypass controls for the coprocessor;
- a request bit through which the host interrupts the coprocessor, which clears itself when the coprocessor acknowledges it;
- two interrupt flags raised by the coprocessor toward the host, which the host clears by writing a one to them.

The RAM itself and the arbitration for it lie outside the block. The port drives an address, write data and strobes, and takes the read byte back combinationally.

Top module: `iram_port`

## Requirements
- R1: After reset the address is 0x0000, the control/status byte reads 0x00, and runOut, bypassOut, irqToCop and hostIrq are all low.
- R2: hostSel selects the register: 0 is the address low byte, 1 the address high byte, 2 data, 3 control/status. Writes to 0 and 1 replace that byte of the address, and reads of 0 and 1 return it.
- R3: A host write to register 2 pulses ramWe in that cycle, with ramAddr equal to the current address and ramWdata equal to hostWdata.
- R4: A host read of register 2 returns ramRdata for the current address in the same cycle and pulses ramRe.
- R5: With control bit 2 (auto-increment) set, every data access (read or write of register 2) advances the address by one at the clock edge that ends the access. With the bit clear, or with no data access, the address keeps its value.
- R6: Auto-increment wraps the address from all ones to zero.
- R7: A control write loads bit 1 (run), bit 2 (auto-increment) and bit 6 (bypass) from the written byte. runOut and bypassOut follow bits 1 and 6. Bits 0 and 7 always read as zero.
- R8: Writing a one to control bit 3 sets the request toward the coprocessor (irqToCop). Writing a zero to bit 3 leaves it unchanged. A copAck pulse clears it, and a simultaneous host set wins over the acknowledge.
- R9: copInt0Set and copInt1Set set flag bits 4 and 5. A control write with a one in a flag bit clears that flag, and a zero leaves it. When a set and a clear of the same flag arrive in one cycle, the set wins.
- R10: hostIrq is high whenever flag bit 4 or flag bit 5 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostSel | input | 2 | Register index for the host access |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte (combinational) |
| ramAddr | output | ADDR_W | Current RAM address |
| ramWdata | output | 8 | Byte written to RAM |
| ramWe | output | 1 | RAM write strobe |
| ramRe | output | 1 | RAM read strobe |
| ramRdata | input | 8 | Byte read from RAM at ramAddr |
| copAck | input | 1 | Coprocessor acknowledge of the host request |
| copInt0Set | input | 1 | Coprocessor raises flag 0 toward the host |
| copInt1Set | input | 1 | Coprocessor raises flag 1 toward the host |
| runOut | output | 1 | Coprocessor run enable |
| bypassOut | output | 1 | Coprocessor pass-through mode |
| irqToCop | output | 1 | Pending host request to the coprocessor |
| hostIrq | output | 1 | Interrupt to the host |

## Verification
The bench builds the port with the default 16-bit address. This keeps the high byte a full eight bits, and a directed load of 0xFFFF followed by a data access reaches the wrap to zero. The bench RAM model decodes only the low ten address bits and aliases the rest, so random high bytes still land in storage the expected model tracks. Random stimulus also produces same-cycle set and clear collisions on the flags and on the request bit.

// File: rtl/iram_pkg.sv
package iram_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    REG_ADDR_LO = 2'd0,
    REG_ADDR_HI = 2'd1,
    REG_DATA    = 2'd2,
    REG_CTRL    = 2'd3
  } regSel_e;

  // bit positions inside the control/status byte
  localparam int BIT_RUN  = 1;
  localparam int BIT_AUTO = 2;
  localparam int BIT_IRQ  = 3;
  localparam int BIT_INT0 = 4;
  localparam int BIT_INT1 = 5;
  localparam int BIT_BYP  = 6;

  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic step;
  } strobes_t;
endpackage

// File: rtl/iram_ctrl.sv
module iram_ctrl
  import iram_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          hostSel,
  input  logic                hostWr,
  input  logic                hostRd,
  input  logic [BIT_BYP:BIT_RUN] ctrlWr,
  input  logic                copAck,
  input  logic                copInt0Set,
  input  logic                copInt1Set,
  output strobes_t            strobes,
  output logic                dataWrite,
  output logic                dataRead,
  output logic [DATA_W-1:0]   ctrlByte,
  output logic                runOut,
  output logic                bypassOut,
  output logic                irqToCop,
  output logic                hostIrq
);
  logic runQ, autoQ, bypQ, irqQ, int0Q, int1Q;
  logic ctrlWrite;

  assign ctrlWrite = hostWr && (hostSel == REG_CTRL);
  assign dataWrite = hostWr && (hostSel == REG_DATA);
  assign dataRead  = hostRd && !hostWr && (hostSel == REG_DATA);

  always_comb begin
    strobes.loadLo = hostWr && (hostSel == REG_ADDR_LO);
    strobes.loadHi = hostWr && (hostSel == REG_ADDR_HI);
    strobes.step   = autoQ && (dataWrite || dataRead);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      autoQ <= 1'b0;
      bypQ  <= 1'b0;
      irqQ  <= 1'b0;
      int0Q <= 1'b0;
      int1Q <= 1'b0;
    end else begin
      if (ctrlWrite) begin
        runQ  <= ctrlWr[BIT_RUN];
        autoQ <= ctrlWr[BIT_AUTO];
        bypQ  <= ctrlWr[BIT_BYP];
      end
      if (ctrlWrite && ctrlWr[BIT_IRQ]) irqQ <= 1'b1;
      else if (copAck)                  irqQ <= 1'b0;
      if (copInt0Set)                          int0Q <= 1'b1;
      else if (ctrlWrite && ctrlWr[BIT_INT0])  int0Q <= 1'b0;
      if (copInt1Set)                          int1Q <= 1'b1;
      else if (ctrlWrite && ctrlWr[BIT_INT1])  int1Q <= 1'b0;
    end
  end

  always_comb begin
    ctrlByte           = '0;
    ctrlByte[BIT_RUN]  = runQ;
    ctrlByte[BIT_AUTO] = autoQ;
    ctrlByte[BIT_IRQ]  = irqQ;
    ctrlByte[BIT_INT0] = int0Q;
    ctrlByte[BIT_INT1] = int1Q;
    ctrlByte[BIT_BYP]  = bypQ;
  end

  assign runOut    = runQ;
  assign bypassOut = bypQ;
  assign irqToCop  = irqQ;
  assign hostIrq   = int0Q | int1Q;
endmodule

// File: rtl/iram_datapath.sv
module iram_datapath
  import iram_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            strobes,
  input  logic [1:0]          hostSel,
  input  logic [DATA_W-1:0]   hostWdata,
  input  logic [DATA_W-1:0]   ctrlByte,
  input  logic [DATA_W-1:0]   ramRdata,
  output logic [ADDR_W-1:0]   addr,
  output logic [DATA_W-1:0]   hostRdata
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] addrLo;
  logic [HI_W-1:0]   addrHi;
  logic [ADDR_W-1:0] addrNext;

  assign addr     = {addrHi, addrLo};
  assign addrNext = addr + ADDR_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLo <= '0;
      addrHi <= '0;
    end else if (strobes.step) begin
      addrLo <= addrNext[DATA_W-1:0];
      addrHi <= addrNext[ADDR_W-1:DATA_W];
    end else begin
      if (strobes.loadLo) addrLo <= hostWdata;
      if (strobes.loadHi) addrHi <= hostWdata[HI_W-1:0];
    end
  end

  always_comb begin
    unique case (hostSel)
      REG_ADDR_LO: hostRdata = addrLo;
      REG_ADDR_HI: hostRdata = DATA_W'(addrHi);
      REG_DATA:    hostRdata = ramRdata;
      default:     hostRdata = ctrlByte;
    endcase
  end
endmodule

// File: rtl/iram_port.sv
module iram_port
  import iram_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        hostSel,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]        ramWdata,
  output logic              ramWe,
  output logic              ramRe,
  input  logic [7:0]        ramRdata,
  input  logic              copAck,
  input  logic              copInt0Set,
  input  logic              copInt1Set,
  output logic              runOut,
  output logic              bypassOut,
  output logic              irqToCop,
  output logic              hostIrq
);
  strobes_t          strobes;
  logic [DATA_W-1:0] ctrlByte;

  iram_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
    .ctrlWr(hostWdata[BIT_BYP:BIT_RUN]), .copAck(copAck),
    .copInt0Set(copInt0Set), .copInt1Set(copInt1Set),
    .strobes(strobes), .dataWrite(ramWe), .dataRead(ramRe), .ctrlByte(ctrlByte),
    .runOut(runOut), .bypassOut(bypassOut), .irqToCop(irqToCop), .hostIrq(hostIrq)
  );

  iram_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hostSel(hostSel),
    .hostWdata(hostWdata), .ctrlByte(ctrlByte), .ramRdata(ramRdata),
    .addr(ramAddr), .hostRdata(hostRdata)
  );

  assign ramWdata = hostWdata;
endmodule

// File: rtl/iram_port_chk.sv
module iram_port_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        hostSel,
  input logic              hostWr,
  input logic              hostRd,
  input logic [7:0]        hostWdata,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              copAck,
  input logic              copInt0Set,
  input logic [7:0]        ctrlByte,
  input logic              runOut,
  input logic              bypassOut,
  input logic              irqToCop,
  input logic              hostIrq
);
  logic dataAcc, ctrlWr;
  assign dataAcc = (hostSel == 2'd2) && (hostWr || hostRd);
  assign ctrlWr  = (hostSel == 2'd3) && hostWr;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && ctrlByte[2]) |=> ramAddr == ADDR_W'($past(ramAddr) + ADDR_W'(1))); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWr || hostRd) |=> $stable(ramAddr)); // R5
  AST_RUN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (runOut == $past(hostWdata[1])) && (bypassOut == $past(hostWdata[6]))); // R7
  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (copAck && !(ctrlWr && hostWdata[3])) |=> !irqToCop); // R8
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    copInt0Set |=> ctrlByte[4] && hostIrq); // R9
endmodule

bind iram_port iram_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
  .hostWdata(hostWdata), .ramAddr(ramAddr), .copAck(copAck), .copInt0Set(copInt0Set),
  .ctrlByte(ctrlByte), .runOut(runOut), .bypassOut(bypassOut), .irqToCop(irqToCop),
  .hostIrq(hostIrq)
);

// File: tb/test_iram_port.sv
module test_iram_port;
  localparam int ADDR_W = 16;
  localparam int MEM_N  = 1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] hostSel = '0;
  logic hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0] hostWdata = '0, hostRdata;
  logic [ADDR_W-1:0] ramAddr;
  logic [7:0] ramWdata, ramRdata;
  logic ramWe, ramRe;
  logic copAck = 1'b0, copInt0Set = 1'b0, copInt1Set = 1'b0;
  logic runOut, bypassOut, irqToCop, hostIrq;

  always #2 clk = ~clk;

  iram_port #(.ADDR_W(ADDR_W)) i_iram_port (.*);

  // bench RAM, aliased on the low ten address bits
  logic [7:0] ram [MEM_N];
  always @(posedge clk) if (ramWe) ram[ramAddr[9:0]] <= ramWdata;
  assign ramRdata = ram[ramAddr[9:0]];

  // expected model
  logic [7:0] expMem [MEM_N];
  logic [15:0] mAddr;
  logic mRun, mAuto, mByp, mIrq, mInt0, mInt1;
  int total = 0, bad = 0;
  bit finished = 0;

  function automatic logic [7:0] expCtrl();
    return {1'b0, mByp, mInt1, mInt0, mIrq, mAuto, mRun, 1'b0};
  endfunction

  function automatic logic [7:0] expRead(input logic [1:0] s);
    case (s)
      2'd0: return mAddr[7:0];
      2'd1: return mAddr[15:8];
      2'd2: return expMem[mAddr[9:0]];
      default: return expCtrl();
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] s, input logic wr, input logic rd,
                      input logic [7:0] wd, input logic ack, input logic s0, input logic s1);
    @(negedge clk);
    hostSel = s; hostWr = wr; hostRd = rd; hostWdata = wd;
    copAck = ack; copInt0Set = s0; copInt1Set = s1;
    #1;
    if (rd && !wr) begin
      chk(s == 2'd2 ? "R4" : (s == 2'd3 ? "R9" : "R2"), hostRdata, expRead(s));
      if (s == 2'd2) chk("R4 ramRe", ramRe, 1);
    end
    if (wr && s == 2'd2) begin
      chk("R3 ramWe", ramWe, 1);
      chk("R3 ramAddr", ramAddr, mAddr);
      chk("R3 ramWdata", ramWdata, wd);
    end
    @(posedge clk);
    // model update from pre-edge state
    begin
      logic acc; logic cw;
      acc = (s == 2'd2) && (wr || rd);
      cw  = (s == 2'd3) && wr;
      if (wr && s == 2'd2) expMem[mAddr[9:0]] = wd;
      if (acc && mAuto) mAddr = mAddr + 16'd1;
      else begin
        if (wr && s == 2'd0) mAddr[7:0]  = wd;
        if (wr && s == 2'd1) mAddr[15:8] = wd;
      end
      if (cw && wd[3]) mIrq = 1'b1; else if (ack) mIrq = 1'b0;
      if (s0) mInt0 = 1'b1; else if (cw && wd[4]) mInt0 = 1'b0;
      if (s1) mInt1 = 1'b1; else if (cw && wd[5]) mInt1 = 1'b0;
      if (cw) begin mRun = wd[1]; mAuto = wd[2]; mByp = wd[6]; end
    end
    #1;
    chk("R5 ramAddr", ramAddr, mAddr);
    chk("R7 runOut", runOut, mRun);
    chk("R7 bypassOut", bypassOut, mByp);
    chk("R8 irqToCop", irqToCop, mIrq);
    chk("R10 hostIrq", hostIrq, mInt0 | mInt1);
  endtask

  task automatic idle(); step(2'd0, 0, 0, 8'h00, 0, 0, 0); endtask

  initial begin
    int unused;
    unused = $urandom(32'd4242);
    for (int i = 0; i < MEM_N; i++) begin
      ram[i] = 8'(i * 7 + 3);
      expMem[i] = 8'(i * 7 + 3);
    end
    mAddr = '0; mRun = 0; mAuto = 0; mByp = 0; mIrq = 0; mInt0 = 0; mInt1 = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 ramAddr", ramAddr, 0);
    chk("R1 runOut", runOut, 0);
    chk("R1 irqToCop", irqToCop, 0);
    chk("R1 hostIrq", hostIrq, 0);
    rstN = 1'b1;
    step(2'd3, 0, 1, 0, 0, 0, 0);               // R1 ctrl reads zero
    // R2 address bytes
    step(2'd0, 1, 0, 8'h34, 0, 0, 0);
    step(2'd1, 1, 0, 8'h12, 0, 0, 0);
    step(2'd0, 0, 1, 0, 0, 0, 0);
    step(2'd1, 0, 1, 0, 0, 0, 0);
    // R5 without auto-increment the address holds
    step(2'd2, 1, 0, 8'hA5, 0, 0, 0);
    step(2'd2, 0, 1, 0, 0, 0, 0);
    // R7 run + auto-increment, bits 0 and 7 ignored
    step(2'd3, 1, 0, 8'h87, 0, 0, 0);
    step(2'd3, 0, 1, 0, 0, 0, 0);
    // R3 block upload, then R4 download after reload
    step(2'd0, 1, 0, 8'h10, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(2'd2, 1, 0, 8'(8'hC0 + i), 0, 0, 0);
    step(2'd0, 1, 0, 8'h10, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(2'd2, 0, 1, 0, 0, 0, 0);
    // R6 wrap
    step(2'd0, 1, 0, 8'hFF, 0, 0, 0);
    step(2'd1, 1, 0, 8'hFF, 0, 0, 0);
    step(2'd2, 0, 1, 0, 0, 0, 0);
    chk("R6 wrap", ramAddr, 0);
    // R7 bypass
    step(2'd3, 1, 0, 8'h46, 0, 0, 0);
    // R8 request: set, zero write no effect, ack clears, set wins over ack
    step(2'd3, 1, 0, 8'h4E, 0, 0, 0);
    step(2'd3, 1, 0, 8'h46, 0, 0, 0);
    step(2'd0, 0, 0, 0, 1, 0, 0);
    step(2'd3, 1, 0, 8'h4E, 1, 0, 0);
    step(2'd0, 0, 0, 0, 1, 0, 0);
    // R9/R10 flags: set, zero write keeps, W1C clears, set wins
    step(2'd0, 0, 0, 0, 0, 1, 1);
    step(2'd3, 0, 1, 0, 0, 0, 0);
    step(2'd3, 1, 0, 8'h06, 0, 0, 0);
    step(2'd3, 1, 0, 8'h16, 0, 0, 0);
    step(2'd3, 1, 0, 8'h26, 0, 0, 1);
    step(2'd3, 1, 0, 8'h26, 0, 0, 0);
    step(2'd3, 0, 1, 0, 0, 0, 0);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] s; logic wr, rd;
      s  = 2'($urandom);
      wr = ($urandom % 3) == 0;
      rd = !wr && (($urandom % 2) == 0);
      step(s, wr, rd, 8'($urandom), ($urandom % 5) == 0,
           ($urandom % 9) == 0, ($urandom % 9) == 0);
    end
    idle();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule